// File: doc/BRIEF.md
# Test-and-reset-bits execution sequencer

This block carries out one read-modify-write instruction that clears memory bits selected by an accumulator mask. A request carries the opcode byte, up to two operand bytes, the accumulator, a width flag (8 or 16 bits), the direct-page base register and the current status byte. The block works out the effective address and reads the operand over a plain synchronous memory bus. It writes back the operand with every bit cleared where the accumulator holds a 1. It sets the zero flag from the AND of operand and accumulator and leaves every other status bit as it came in.

The sequencer is cycle accurate. An absolute-address instruction (opcode 0x1C) spends 6 cycles and a direct-page instruction (opcode 0x14) spends 5. A 16-bit accumulator adds 2 cycles. In direct-page mode only, a base register with a nonzero low byte adds 1 more cycle. Cycles that neither read nor write leave both bus strobes low.

Requests enter through a valid/ready pair. `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and all request fields are sampled on that edge only. While an instruction is in flight `req_ready` stays low. The source holds its request, or any later one, until the block is idle again. The memory side has no handshake: the memory must return read data in the cycle after the read strobe.

Top module: `tstclr_exec`

## Requirements
- R1: `req_ready` is high exactly when no instruction is in flight. A request is taken only on an edge with `req_valid` and `req_ready` both high. A valid request held during execution is not taken again.
- R2: Counting from the first cycle after acceptance through the cycle where `done` is high, an 8-bit absolute instruction takes 6 cycles and an 8-bit direct-page instruction with base low byte zero takes 5.
- R3: A 16-bit accumulator (`req_acc_wide` = 1) lengthens either mode by exactly 2 cycles.
- R4: Direct-page mode with `req_dp_base[7:0]` nonzero adds exactly 1 cycle. In absolute mode the base register has no effect on timing or address.
- R5: The effective address is {operand high, operand low} in absolute mode. In direct-page mode it is `req_dp_base` plus the zero-extended low operand, modulo 2^16.
- R6: Memory is rewritten as M AND NOT A. In 8-bit mode only the byte at the effective address changes, and address+1 keeps its contents. In 16-bit mode the low byte sits at the effective address and the high byte at address+1, modulo 2^16.
- R7: Reads go low byte first, then high byte. Writes go high byte first, then low byte. Every read comes before any write, read and write strobes are never high together, and the last write falls in the `done` cycle.
- R8: Bit 1 of `flags_out` is set exactly when (M AND A) is zero over the active width. The other seven bits equal `req_flags` as sampled at acceptance, and they stay unchanged while the instruction runs.
- R9: `done` is a one-cycle pulse in the final cycle, and `req_ready` is high in the cycle after it.
- R10: A request whose opcode is neither 0x1C nor 0x14 is taken and dropped. It causes no bus strobe and no `done`, leaves `flags_out` unchanged, and `req_ready` stays high.
- R11: After reset the block is idle: `req_ready` high, both strobes low, `done` low, `flags_out` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_opcode | input | 8 | Opcode byte (0x1C absolute, 0x14 direct page) |
| req_oper_lo | input | 8 | First operand byte |
| req_oper_hi | input | 8 | Second operand byte (absolute only) |
| req_acc | input | 16 | Accumulator mask |
| req_acc_wide | input | 1 | 1 = 16-bit accumulator, 0 = 8-bit |
| req_dp_base | input | 16 | Direct-page base register |
| req_flags | input | 8 | Status byte on entry, zero flag in bit 1 |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | High in the final cycle of an instruction |
| flags_out | output | 8 | Status byte after the instruction |

## Verification
The assertions assume the block leaves reset through `rst_n` before any request arrives. They also assume the memory answers every read strobe in the next cycle, because the strobe-order and status-hold properties only make sense against a memory that never stalls. The bench memory is a registered model that returns data one cycle after the strobe. Requests are driven away from the clock edge and dropped in the first idle cycle after `done`, or held through a whole run on purpose to exercise back-pressure.

// File: rtl/tstclr_pkg.sv
package tstclr_pkg;

  localparam logic [7:0] OPC_ABS = 8'h1C;
  localparam logic [7:0] OPC_DPG = 8'h14;
  localparam int         ZFLAG_BIT = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_OPL,
    ST_OPH,
    ST_DPX,
    ST_RDL,
    ST_RDH,
    ST_MOD,
    ST_WRH,
    ST_WRL
  } phase_t;

endpackage

// File: rtl/tstclr_agen.sv
module tstclr_agen #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              sel_dp,
  input  logic [BYTE_W-1:0] opnd_lo,
  input  logic [BYTE_W-1:0] opnd_hi,
  input  logic [ADDR_W-1:0] dp_base,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misaligned
);
  localparam int PAD_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] abs_addr;
  logic [ADDR_W-1:0] dpg_addr;

  assign abs_addr   = ADDR_W'({opnd_hi, opnd_lo});
  assign dpg_addr   = dp_base + {{PAD_W{1'b0}}, opnd_lo};
  assign eff_addr   = sel_dp ? dpg_addr : abs_addr;
  assign misaligned = sel_dp && (dp_base[BYTE_W-1:0] != '0);

endmodule

// File: rtl/tstclr_lanes.sv
module tstclr_lanes #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic [LANES*BYTE_W-1:0] mem_val,
  input  logic [LANES*BYTE_W-1:0] acc_val,
  input  logic                    wide,
  output logic [LANES*BYTE_W-1:0] cleared,
  output logic                    all_zero
);
  logic [LANES-1:0] lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit BASE_LANE = (g == 0);
    logic [BYTE_W-1:0] m_b;
    logic [BYTE_W-1:0] a_b;
    assign m_b = mem_val[g*BYTE_W +: BYTE_W];
    assign a_b = acc_val[g*BYTE_W +: BYTE_W];
    assign cleared[g*BYTE_W +: BYTE_W] = m_b & ~a_b;
    assign lane_hit[g] = (BASE_LANE || wide) && (|(m_b & a_b));
  end

  assign all_zero = ~|lane_hit;

endmodule

// File: rtl/tstclr_ctl.sv
module tstclr_ctl
  import tstclr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  logic   is_dp,
  input  logic   wide,
  input  logic   misal,
  output phase_t phase,
  output logic   ready,
  output logic   done
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    case (phase)
      ST_IDLE: if (go) nxt = ST_OPC;
      ST_OPC:  nxt = ST_OPL;
      ST_OPL:  nxt = is_dp ? (misal ? ST_DPX : ST_RDL) : ST_OPH;
      ST_OPH:  nxt = ST_RDL;
      ST_DPX:  nxt = ST_RDL;
      ST_RDL:  nxt = wide ? ST_RDH : ST_MOD;
      ST_RDH:  nxt = ST_MOD;
      ST_MOD:  nxt = wide ? ST_WRH : ST_WRL;
      ST_WRH:  nxt = ST_WRL;
      ST_WRL:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= ST_IDLE;
    else        phase <= nxt;
  end

  assign ready = (phase == ST_IDLE);
  assign done  = (phase == ST_WRL);

  // Independent cycle counter used only by the timing check below.
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] exp_cnt;

  assign exp_cnt = (is_dp ? CNT_W'(5) : CNT_W'(6))
                 + (wide ? CNT_W'(2) : CNT_W'(0))
                 + (misal ? CNT_W'(1) : CNT_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (go)     run_cnt <= CNT_W'(1);
    else if (!ready) run_cnt <= run_cnt + CNT_W'(1);
  end

  // R2, R3, R4: total length matches mode, width and alignment
  p_cycle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == exp_cnt));

  // R9: single-cycle completion, then idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ready && !done));

endmodule

// File: rtl/tstclr_exec.sv
module tstclr_exec
  import tstclr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [BYTE_W-1:0] req_oper_lo,
  input  logic [BYTE_W-1:0] req_oper_hi,
  input  logic [ACC_W-1:0]  req_acc,
  input  logic              req_acc_wide,
  input  logic [ADDR_W-1:0] req_dp_base,
  input  logic [FLAG_W-1:0] req_flags,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int LANES = ACC_W / BYTE_W;
  localparam logic [FLAG_W-1:0] ZMASK = FLAG_W'(1) << ZFLAG_BIT;

  phase_t phase;

  logic              op_abs, op_dpg, go;
  logic [ADDR_W-1:0] ea_d;
  logic              pen_d;

  logic [ADDR_W-1:0] ea_q;
  logic [ACC_W-1:0]  acc_q;
  logic              wide_q, dp_q, pen_q;
  logic [ACC_W-1:0]  opnd_q;
  logic [ACC_W-1:0]  opnd_view;
  logic [ACC_W-1:0]  res_q;
  logic [ACC_W-1:0]  cleared;
  logic              all_zero;
  logic [FLAG_W-1:0] flags_q;

  assign op_abs = (req_opcode == OPC_ABS);
  assign op_dpg = (req_opcode == OPC_DPG);
  assign go     = req_valid && req_ready && (op_abs || op_dpg);

  tstclr_agen #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_agen (
    .sel_dp     (op_dpg),
    .opnd_lo    (req_oper_lo),
    .opnd_hi    (req_oper_hi),
    .dp_base    (req_dp_base),
    .eff_addr   (ea_d),
    .misaligned (pen_d)
  );

  tstclr_ctl #(.CNT_W(4)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .is_dp (dp_q),
    .wide  (wide_q),
    .misal (pen_q),
    .phase (phase),
    .ready (req_ready),
    .done  (done)
  );

  // Operand as seen in the modify cycle: the last byte read is still on the bus.
  always_comb begin
    opnd_view = opnd_q;
    if (phase == ST_MOD) begin
      if (wide_q) opnd_view[BYTE_W +: BYTE_W] = mem_rdata;
      else        opnd_view[0 +: BYTE_W]      = mem_rdata;
    end
  end

  tstclr_lanes #(.BYTE_W(BYTE_W), .LANES(LANES)) u_lanes (
    .mem_val  (opnd_view),
    .acc_val  (acc_q),
    .wide     (wide_q),
    .cleared  (cleared),
    .all_zero (all_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q    <= '0;
      acc_q   <= '0;
      wide_q  <= 1'b0;
      dp_q    <= 1'b0;
      pen_q   <= 1'b0;
      opnd_q  <= '0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      if (go) begin
        ea_q    <= ea_d;
        acc_q   <= req_acc;
        wide_q  <= req_acc_wide;
        dp_q    <= op_dpg;
        pen_q   <= pen_d;
        flags_q <= req_flags;
      end
      if (phase == ST_RDH) opnd_q[0 +: BYTE_W] <= mem_rdata;
      if (phase == ST_MOD) begin
        res_q              <= cleared;
        flags_q[ZFLAG_BIT] <= all_zero;
      end
    end
  end

  assign mem_rd    = (phase == ST_RDL) || (phase == ST_RDH);
  assign mem_wr    = (phase == ST_WRH) || (phase == ST_WRL);
  assign mem_addr  = ((phase == ST_RDH) || (phase == ST_WRH)) ? (ea_q + ADDR_W'(1)) : ea_q;
  assign mem_wdata = (phase == ST_WRH) ? res_q[BYTE_W +: BYTE_W] : res_q[0 +: BYTE_W];
  assign flags_out = flags_q;

  // R7: a cycle is a read or a write, never both
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R7: once writing has begun no further read is issued
  p_no_read_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_rd);

  // R8: non-zero flag bits hold during an instruction
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> (((flags_out ^ $past(flags_out)) & ~ZMASK) == '0));

  // R10: a dropped request leaves the block idle
  p_bad_opcode_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(op_abs || op_dpg)) |=> req_ready);

endmodule

// File: tb/tstclr_exec_test.sv
module tstclr_exec_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_opcode, req_oper_lo, req_oper_hi;
  logic [15:0] req_acc;
  logic        req_acc_wide;
  logic [15:0] req_dp_base;
  logic [7:0]  req_flags;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [7:0]  flags_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] mem [logic [15:0]];

  always #10 clk = ~clk;

  tstclr_exec uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_oper_lo(req_oper_lo), .req_oper_hi(req_oper_hi),
    .req_acc(req_acc), .req_acc_wide(req_acc_wide), .req_dp_base(req_dp_base),
    .req_flags(req_flags),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .flags_out(flags_out)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    if (mem_wr) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input string ctag, input logic [7:0] op,
                         input logic [7:0] lo, input logic [7:0] hi,
                         input logic [15:0] acc, input bit wide,
                         input logic [15:0] dp, input logic [7:0] fl,
                         input logic [7:0] mlo, input logic [7:0] mhi,
                         input bit hold_valid);
    bit          is_dp;
    logic [15:0] ea, ea1;
    int          exp_cyc, cyc, nrd, nwr, busy_ready, last_rd, first_wr, last_wr;
    logic [15:0] rd_a [2];
    logic [15:0] wr_a [2];
    logic [7:0]  e_lo, e_hi, e_fl;
    bit          z;
    is_dp   = (op == 8'h14);
    ea      = is_dp ? dp + {8'h00, lo} : {hi, lo};
    ea1     = ea + 16'd1;
    exp_cyc = (is_dp ? 5 : 6) + (wide ? 2 : 0) + ((is_dp && dp[7:0] != 8'h00) ? 1 : 0);
    e_lo    = mlo & ~acc[7:0];
    e_hi    = wide ? (mhi & ~acc[15:8]) : mhi;
    z       = wide ? (({mhi, mlo} & acc) == 16'h0) : ((mlo & acc[7:0]) == 8'h0);
    e_fl    = (fl & ~8'h02) | {6'b0, z, 1'b0};
    mem[ea]  = mlo;
    mem[ea1] = mhi;
    rd_a[0] = '0; rd_a[1] = '0; wr_a[0] = '0; wr_a[1] = '0;
    cyc = 0; nrd = 0; nwr = 0; busy_ready = 0; last_rd = 0; first_wr = 99; last_wr = 0;

    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_opcode = op; req_oper_lo = lo; req_oper_hi = hi; req_acc = acc;
    req_acc_wide = wide; req_dp_base = dp; req_flags = fl; req_valid = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (!hold_valid) req_valid = 1'b0;
      if (req_ready && !done) busy_ready++;
      if (mem_rd) begin
        if (nrd < 2) rd_a[nrd] = mem_addr;
        nrd++; last_rd = k;
      end
      if (mem_wr) begin
        if (nwr < 2) wr_a[nwr] = mem_addr;
        nwr++; last_wr = k;
        if (first_wr == 99) first_wr = k;
      end
      if (done) begin cyc = k; break; end
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(cyc == exp_cyc, ctag, "cycle count", cyc, exp_cyc);
    chk(busy_ready == 0, "R1", "ready during execution", busy_ready, 0);
    chk(req_ready && !done, "R9", "idle after done", {req_ready, done}, 2'b10);
    chk(nrd == (wide ? 2 : 1), "R7", "read count", nrd, wide ? 2 : 1);
    chk(nwr == (wide ? 2 : 1), "R7", "write count", nwr, wide ? 2 : 1);
    chk(last_rd < first_wr && last_wr == cyc, "R7", "read/write ordering", last_rd, first_wr);
    chk(rd_a[0] == ea, "R5", "first read address", rd_a[0], ea);
    if (wide) begin
      chk(rd_a[1] == ea1, "R7", "second read address", rd_a[1], ea1);
      chk(wr_a[0] == ea1 && wr_a[1] == ea, "R7", "write order high then low", wr_a[0], ea1);
    end else begin
      chk(wr_a[0] == ea, "R6", "write address", wr_a[0], ea);
    end
    chk(mem[ea] == e_lo, "R6", "low byte result", mem[ea], e_lo);
    chk(mem[ea1] == e_hi, "R6", "byte at address+1", mem[ea1], e_hi);
    chk(flags_out == e_fl, "R8", "status byte", flags_out, e_fl);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(!mem_rd && !mem_wr, "R11", "strobes after reset", {mem_rd, mem_wr}, 0);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    chk(flags_out == 8'h00, "R11", "status after reset", flags_out, 0);
  endtask

  task automatic t_abs_narrow();
    run_one("R2", 8'h1C, 8'h34, 8'h12, 16'h00F0, 1'b0, 16'h0000, 8'hFF, 8'hA5, 8'h77, 1'b0);
  endtask

  task automatic t_abs_narrow_high_ignored();
    // R8: upper accumulator byte overlaps memory but 8-bit mode ignores it
    run_one("R2", 8'h1C, 8'h80, 8'h20, 16'hFF01, 1'b0, 16'h0000, 8'h00, 8'h02, 8'hFF, 1'b0);
  endtask

  task automatic t_abs_wide();
    run_one("R3", 8'h1C, 8'h00, 8'h40, 16'h0F0F, 1'b1, 16'h0000, 8'h00, 8'h3C, 8'hC3, 1'b0);
  endtask

  task automatic t_abs_ignores_dp();
    // R4: misaligned base has no effect in absolute mode
    run_one("R4", 8'h1C, 8'h10, 8'h50, 16'h00FF, 1'b0, 16'h00FF, 8'h81, 8'h0F, 8'h11, 1'b0);
  endtask

  task automatic t_abs_wrap_wide();
    run_one("R3", 8'h1C, 8'hFF, 8'hFF, 16'hAAAA, 1'b1, 16'h0000, 8'h42, 8'h55, 8'h55, 1'b0);
  endtask

  task automatic t_dp_aligned_narrow();
    run_one("R2", 8'h14, 8'h10, 8'h99, 16'h0055, 1'b0, 16'h0200, 8'h00, 8'hAA, 8'h33, 1'b0);
  endtask

  task automatic t_dp_misaligned_narrow();
    run_one("R4", 8'h14, 8'h20, 8'h00, 16'h0003, 1'b0, 16'h0305, 8'h7F, 8'h06, 8'h44, 1'b0);
  endtask

  task automatic t_dp_aligned_wide();
    run_one("R3", 8'h14, 8'h40, 8'h00, 16'hFFFF, 1'b1, 16'h1100, 8'hFD, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_dp_misaligned_wide();
    run_one("R4", 8'h14, 8'h01, 8'h00, 16'h8001, 1'b1, 16'h12FF, 8'h00, 8'h81, 8'h80, 1'b0);
  endtask

  task automatic t_dp_wrap();
    // R5: base plus offset wraps to the bottom of the address space
    run_one("R4", 8'h14, 8'h20, 8'h00, 16'h1234, 1'b1, 16'hFFF0, 8'h0C, 8'hFF, 8'hFF, 1'b0);
  endtask

  task automatic t_backpressure();
    // R1: request held valid for the whole run is taken once
    run_one("R2", 8'h1C, 8'h00, 8'h60, 16'h0010, 1'b0, 16'h0000, 8'h02, 8'h1F, 8'h00, 1'b1);
  endtask

  task automatic t_bad_opcode();
    logic [7:0] fl_before;
    int         act;
    fl_before = flags_out;
    act = 0;
    @(negedge clk);
    req_opcode = 8'hEA; req_oper_lo = 8'h00; req_oper_hi = 8'h70; req_acc = 16'hFFFF;
    req_acc_wide = 1'b1; req_dp_base = 16'h0000; req_flags = 8'h5A; req_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (mem_rd || mem_wr || done || !req_ready) act++;
    end
    chk(act == 0, "R10", "activity after unknown opcode", act, 0);
    chk(flags_out == fl_before, "R10", "status after unknown opcode", flags_out, fl_before);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_opcode = 8'h00; req_oper_lo = 8'h00; req_oper_hi = 8'h00;
    req_acc = 16'h0; req_acc_wide = 1'b0; req_dp_base = 16'h0; req_flags = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_abs_narrow();
    t_abs_narrow_high_ignored();
    t_abs_wide();
    t_abs_ignores_dp();
    t_abs_wrap_wide();
    t_dp_aligned_narrow();
    t_dp_misaligned_narrow();
    t_dp_aligned_wide();
    t_dp_misaligned_wide();
    t_dp_wrap();
    t_backpressure();
    t_bad_opcode();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule